// File: doc/BRIEF.md
# Byte-Wide Shared Pin Port Controller

This block manages eight device pins that make up one byte-wide parallel port. Each pin is either a plain general-purpose I/O line, run from three bus registers, or is handed over bit by bit to a synchronous serial peripheral. A general-purpose pin drives the value held in an output latch, but only when its direction bit is set. A pin owned by the synchronous peripheral takes its level and its enable from that peripheral.

An asynchronous serial transmitter/receiver also uses two fixed pins, one for transmit and one for receive. The ownership register has no say over those two pins. Their ownership bits are not implemented. When the transmitter is enabled, it drives its pin directly. Reads of the data address return the pin levels after a two-flop synchronizer, not the latch. Software can therefore load the latch while a pin is still an input, and the pin starts driving that value on the cycle its direction bit is set.

Top module: `pin_mux_port`

## Requirements
- R1: After reset, the output latch, the direction register and the ownership register are all zero. Every pin enable `pin_oe` is low, and reads at address 1 and address 2 return 0.
- R2: A write to address 0 while a pin's direction bit is 0 does not enable that pin. On the cycle after its direction bit is later set, the pin drives the value written earlier.
- R3: For a general-purpose pin, `pin_oe` equals its direction bit, and `pin_out` equals its latch bit.
- R4: A read at address 0 returns the pin levels (`pin_in`), not the latch. A change on `pin_in` first appears in the read data two clock edges later.
- R5: A pin whose ownership bit is 1 takes `pin_out` and `pin_oe` from `sync_out` and `sync_oe`. Its latch bit and direction bit have no effect on it.
- R6: Ownership bits at positions TX_PIN (default 1) and RX_PIN (default 0) always read 0. Writing 1 to them does not hand those pins to the synchronous peripheral.
- R7: While `uart_tx_en` is 1, pin TX_PIN has `pin_oe` high and `pin_out` equal to `uart_tx`, whatever its direction bit and latch bit hold.
- R8: `uart_rx` follows `pin_in[RX_PIN]`, and `sync_in` follows `pin_in`.
- R9: Address 3 reads 0. Writes to address 3 change no register.
- R10: Address 1 reads back the direction register, and address 2 reads back the ownership register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 data, 1 direction, 2 ownership, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Levels present on the pins |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| sync_out | input | 8 | Synchronous peripheral output values |
| sync_oe | input | 8 | Synchronous peripheral output enables |
| sync_in | output | 8 | Pin levels passed to the synchronous peripheral |
| uart_tx | input | 1 | Asynchronous transmitter data |
| uart_tx_en | input | 1 | Asynchronous transmitter takes pin TX_PIN |
| uart_rx | output | 1 | Receive pin level passed to the asynchronous receiver |

## Verification
The hardest case is a pin that is driven by the port and read back at the same time. Its read value is a mix of the latch, for output bits, and the external level, for input bits, and it lags by two edges. The bench models the pad as an enable-controlled mux between `pin_out` and an external byte. It loads a latch value that differs from the external byte, then reads at one edge and at two edges after a change, so that the latch and the synchronizer delay are both exposed. The uart pins are also given ownership bits set to 1, with peripheral enables all high, so that the bench can show these bits are ignored.

// File: rtl/pin_mux_port.sv
module pin_mux_port #(
  parameter int W      = 8,
  parameter int TX_PIN = 1,
  parameter int RX_PIN = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] sync_out,
  input  logic [W-1:0] sync_oe,
  output logic [W-1:0] sync_in,
  input  logic         uart_tx,
  input  logic         uart_tx_en,
  output logic         uart_rx
);
  localparam logic [1:0]   A_DATA = 2'd0;
  localparam logic [1:0]   A_DIR  = 2'd1;
  localparam logic [1:0]   A_OWN  = 2'd2;
  localparam logic [W-1:0] TX_BIT = W'(1) << TX_PIN;
  localparam logic [W-1:0] RX_BIT = W'(1) << RX_PIN;
  localparam logic [W-1:0] OWN_OK = ~(TX_BIT | RX_BIT);

  logic [W-1:0] latch_q, dir_q, own_q, s1_q, s2_q;
  logic [W-1:0] tx_sel, gp_out, gp_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      own_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  latch_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_OWN:   own_q   <= bus_wdata & OWN_OK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  assign tx_sel  = uart_tx_en ? TX_BIT : '0;
  assign gp_out  = (latch_q & ~tx_sel) | ({W{uart_tx}} & tx_sel);
  assign gp_oe   = dir_q | tx_sel;
  assign pin_out = (own_q & sync_out) | (~own_q & gp_out);
  assign pin_oe  = (own_q & sync_oe)  | (~own_q & gp_oe);
  assign sync_in = pin_in;
  assign uart_rx = pin_in[RX_PIN];

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = s2_q;
      A_DIR:   bus_rdata = dir_q;
      A_OWN:   bus_rdata = own_q;
      default: bus_rdata = '0;
    endcase
  end

  logic [1:0] up_cnt;
  logic [W-1:0] gp_mask;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
  end
  assign gp_mask = ~own_q & ~tx_sel;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && own_q == '0 && latch_q == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=>
      (((pin_oe ^ $past(bus_wdata)) & gp_mask) == '0));

  p_latch_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=>
      (((pin_out ^ $past(bus_wdata)) & pin_oe & gp_mask) == '0));

  p_read_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd2 && bus_addr == A_DATA) |-> bus_rdata == $past(pin_in, 2));

  p_spare_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=>
      ($stable(dir_q) && $stable(own_q) && $stable(latch_q)));
endmodule

// File: tb/pin_mux_port_bench.sv
module pin_mux_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in, pin_out, pin_oe, sync_in;
  logic [7:0] sync_out = '0, sync_oe = '0, ext = '0;
  logic       uart_tx = 1'b0, uart_tx_en = 1'b0, uart_rx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pin_mux_port u_pin_mux_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .sync_out(sync_out), .sync_oe(sync_oe),
    .sync_in(sync_in), .uart_tx(uart_tx), .uart_tx_en(uart_tx_en), .uart_rx(uart_rx)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", pin_oe, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 own", v, 8'h00);
  endtask

  task automatic t_preload;
    wr(2'd0, 8'hA5);
    chk("R2 no drive", pin_oe, 8'h00);
    wr(2'd1, 8'hF0);
    chk("R2 oe", pin_oe, 8'hF0);
    chk("R2 out", pin_out & 8'hF0, 8'hA0);
    chk("R3 out", pin_out, 8'hA5);
  endtask

  task automatic t_read;
    logic [7:0] v;
    ext = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R4 pins not latch", v, 8'hAC);
    ext = 8'h03;
    @(negedge clk);
    rd(2'd0, v); chk("R4 one edge", v, 8'hAC);
    @(negedge clk);
    rd(2'd0, v); chk("R4 two edges", v, 8'hA3);
    rd(2'd1, v); chk("R10 dir", v, 8'hF0);
  endtask

  task automatic t_rx;
    ext = 8'h01; #1;
    chk("R8 rx high", {7'd0, uart_rx}, 8'h01);
    chk("R8 sync_in", sync_in, 8'hA1);
    ext = 8'h00; #1;
    chk("R8 rx low", {7'd0, uart_rx}, 8'h00);
  endtask

  task automatic t_own;
    logic [7:0] v;
    sync_out = 8'hFF; sync_oe = 8'h04;
    wr(2'd2, 8'h0C);
    rd(2'd2, v); chk("R10 own", v, 8'h0C);
    chk("R5 oe", pin_oe, 8'hF4);
    chk("R5 out", pin_out, 8'hAD);
  endtask

  task automatic t_uart_bits;
    logic [7:0] v;
    sync_out = 8'h00; sync_oe = 8'hFF;
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R6 readback", v, 8'hFC);
    chk("R6 oe", pin_oe, 8'hFC);
    chk("R6 out", pin_out, 8'h01);
  endtask

  task automatic t_tx;
    wr(2'd2, 8'h00);
    sync_oe = 8'h00;
    uart_tx = 1'b1; uart_tx_en = 1'b1; #1;
    chk("R7 oe", pin_oe, 8'hF2);
    chk("R7 out", pin_out, 8'hA7);
    uart_tx = 1'b0; #1;
    chk("R7 low", pin_out, 8'hA5);
    uart_tx_en = 1'b0; #1;
    chk("R7 release", pin_oe, 8'hF0);
  endtask

  task automatic t_spare;
    logic [7:0] v;
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R9 read", v, 8'h00);
    rd(2'd1, v); chk("R9 dir kept", v, 8'hF0);
    rd(2'd2, v); chk("R9 own kept", v, 8'h00);
    chk("R9 latch kept", pin_out, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_preload();
    t_read();
    t_rx();
    t_own();
    t_uart_bits();
    t_tx();
    t_spare();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule